// File: doc/BRIEF.md
# Host Queue Threshold Unit

This block sits behind the register port of a host controller and holds three word-wide queues. The command queue is filled by host writes and drained by the serial engine. The response queue and the in-band-interrupt (IBI) queue are filled by the engine and drained by host reads. Each queue keeps a level, and that level is compared against a programmable 8-bit threshold.

The command queue reports ready when its free-slot count reaches its threshold. The response and IBI queues report when their fill count reaches theirs. Host misuse of the queue ports sets one-cycle programming-error pulses: a write to a full command queue, or a read from an empty response or IBI queue.

The register bus is a single-cycle strobe interface with a 3-bit word index on `bus_addr_i`. Read data appears on `bus_rdata_o` one clock after the read strobe and holds until the next read. A command descriptor is two or four consecutive writes to the command port. The queue treats each write as one entry.

Top module: `qthr_top`

## Requirements
- R1: After reset all three queues are empty, the threshold register reads 0x01010101, `cmd_ready_o` is 1, and `resp_ready_o` and `ibi_thld_o` are 0.
- R2: Register index 3 is the threshold register. It reads back what was written: command free-slot threshold in [7:0], response threshold in [15:8], IBI data threshold in [23:16] and IBI status threshold in [31:24].
- R3: `cmd_ready_o` is 1 exactly when the free command-slot count is at least the command threshold, where a threshold of 0 counts as 1. A threshold larger than the depth keeps it at 0.
- R4: `resp_ready_o` is 1 exactly when the response queue level is at least the response threshold, where 0 counts as 1.
- R5: `ibi_thld_o` is 1 exactly when the IBI queue level is at least the IBI status threshold, where 0 counts as 1.
- R6: Register index 4 reads the free command-slot count in [8:0], the response level in [18:10] and the IBI level in [28:20]. All other bits read 0.
- R7: Register index 5 reads the command/response depth in entries at [7:0] and the IBI depth in words at [15:8]. All other bits read 0.
- R8: Words written to register index 0 are presented on `cmd_data_o` in write order. `cmd_pop_i` advances the queue, and `cmd_avail_o` is 1 while the queue is not empty.
- R9: Reads of index 1 (response port) and index 2 (IBI port) return the engine-pushed words of that queue in push order, on `bus_rdata_o` the cycle after the read.
- R10: A write to index 0 while the command queue is full pulses `err_cmd_ovf_o` for one cycle in the next cycle. The word is dropped and the level is unchanged.
- R11: A read of index 1 or 2 while that queue is empty returns 0 and pulses `err_resp_udf_o` or `err_ibi_udf_o` in the next cycle. No level changes.
- R12: `resp_full_o` and `ibi_full_o` are 1 when the respective queue holds its depth of words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 3 | Register word index |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, one cycle after the read |
| cmd_pop_i | input | 1 | Engine takes the head command word |
| cmd_data_o | output | 32 | Head command word |
| cmd_avail_o | output | 1 | Command queue not empty |
| resp_push_i | input | 1 | Engine pushes a response word |
| resp_data_i | input | 32 | Response word |
| resp_full_o | output | 1 | Response queue full |
| ibi_push_i | input | 1 | Engine pushes an IBI word |
| ibi_data_i | input | 32 | IBI word |
| ibi_full_o | output | 1 | IBI queue full |
| cmd_ready_o | output | 1 | Free command slots reach the threshold |
| resp_ready_o | output | 1 | Response level reaches the threshold |
| ibi_thld_o | output | 1 | IBI level reaches the status threshold |
| err_cmd_ovf_o | output | 1 | Command overflow pulse |
| err_resp_udf_o | output | 1 | Response underflow pulse |
| err_ibi_udf_o | output | 1 | IBI underflow pulse |

## Verification
The properties assume that the engine never pushes into a full response or IBI queue, never pops an empty command queue, and that a host write and a host read never come in the same cycle. The stimulus keeps to these by tracking every level in its own model. It gates each engine push and pop on that model, and it issues one bus access at a time. Host misuse of the ports is driven deliberately, because overflow and underflow are behaviour the block defines.

// File: rtl/qthr_pkg.sv
package qthr_pkg;
  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] IDX_CMD  = 3'd0;
  localparam logic [AW-1:0] IDX_RESP = 3'd1;
  localparam logic [AW-1:0] IDX_IBI  = 3'd2;
  localparam logic [AW-1:0] IDX_THR  = 3'd3;
  localparam logic [AW-1:0] IDX_LVL  = 3'd4;
  localparam logic [AW-1:0] IDX_SIZE = 3'd5;

  typedef struct packed {
    logic [7:0] ibi_stat;
    logic [7:0] ibi_data;
    logic [7:0] resp;
    logic [7:0] cmd;
  } thr_t;

  localparam thr_t THR_RESET = '{8'd1, 8'd1, 8'd1, 8'd1};

  function automatic logic [7:0] eff_thr(input logic [7:0] raw);
    return (raw == 8'd0) ? 8'd1 : raw;
  endfunction
endpackage

// File: rtl/qthr_fifo.sv
module qthr_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign full_o  = (lvl_q == LW'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rptr_q];
  assign level_o = lvl_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (do_push) wptr_d = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + PW'(1);
    if (do_pop)  rptr_d = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + PW'(1);
    case ({do_push, do_pop})
      2'b10:   lvl_d = lvl_q + LW'(1);
      2'b01:   lvl_d = lvl_q - LW'(1);
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end
endmodule

// File: rtl/qthr_cmp.sv
module qthr_cmp #(
  parameter int LW  = 4,
  localparam int CW = (LW > 8) ? LW : 8
) (
  input  logic [LW-1:0] count_i,
  input  logic [7:0]    thr_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_ext, thr_ext;
  assign cnt_ext = CW'(count_i);
  assign thr_ext = CW'(qthr_pkg::eff_thr(thr_i));
  assign hit_o   = (cnt_ext >= thr_ext);
endmodule

// File: rtl/qthr_thr_reg.sv
module qthr_thr_reg
  import qthr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output thr_t        thr_o
);
  thr_t thr_q, thr_d;

  always_comb begin
    thr_d = thr_q;
    if (we_i) thr_d = thr_t'(wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_q <= THR_RESET;
    else         thr_q <= thr_d;
  end

  assign thr_o = thr_q;
endmodule

// File: rtl/qthr_top.sv
module qthr_top
  import qthr_pkg::*;
#(
  parameter int CR_DEPTH  = 8,
  parameter int IBI_DEPTH = 16,
  localparam int CLW      = $clog2(CR_DEPTH + 1),
  localparam int ILW      = $clog2(IBI_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  bus_addr_i,
  input  logic        bus_wr_i,
  input  logic        bus_rd_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic        cmd_pop_i,
  output logic [31:0] cmd_data_o,
  output logic        cmd_avail_o,
  input  logic        resp_push_i,
  input  logic [31:0] resp_data_i,
  output logic        resp_full_o,
  input  logic        ibi_push_i,
  input  logic [31:0] ibi_data_i,
  output logic        ibi_full_o,
  output logic        cmd_ready_o,
  output logic        resp_ready_o,
  output logic        ibi_thld_o,
  output logic        err_cmd_ovf_o,
  output logic        err_resp_udf_o,
  output logic        err_ibi_udf_o
);
  logic           wr_cmd, wr_thr, rd_resp, rd_ibi;
  logic           cmd_full, cmd_empty, resp_empty, ibi_empty;
  logic [CLW-1:0] cmd_lvl, resp_lvl, cmd_free;
  logic [ILW-1:0] ibi_lvl;
  logic [31:0]    resp_head, ibi_head, lvl_word, size_word, rd_mux;
  logic [31:0]    rdata_q, rdata_d;
  logic           ovf_q, ovf_d, rudf_q, rudf_d, iudf_q, iudf_d;
  thr_t           thr;

  assign wr_cmd  = bus_wr_i & (bus_addr_i == IDX_CMD);
  assign wr_thr  = bus_wr_i & (bus_addr_i == IDX_THR);
  assign rd_resp = bus_rd_i & (bus_addr_i == IDX_RESP);
  assign rd_ibi  = bus_rd_i & (bus_addr_i == IDX_IBI);

  qthr_thr_reg u_thr (
    .clk_i, .rst_ni, .we_i(wr_thr), .wdata_i(bus_wdata_i), .thr_o(thr)
  );

  qthr_fifo #(.DW(32), .DEPTH(CR_DEPTH)) u_cmd_q (
    .clk_i, .rst_ni, .push_i(wr_cmd), .wdata_i(bus_wdata_i), .pop_i(cmd_pop_i),
    .rdata_o(cmd_data_o), .level_o(cmd_lvl), .full_o(cmd_full), .empty_o(cmd_empty)
  );

  qthr_fifo #(.DW(32), .DEPTH(CR_DEPTH)) u_resp_q (
    .clk_i, .rst_ni, .push_i(resp_push_i), .wdata_i(resp_data_i), .pop_i(rd_resp),
    .rdata_o(resp_head), .level_o(resp_lvl), .full_o(resp_full_o), .empty_o(resp_empty)
  );

  qthr_fifo #(.DW(32), .DEPTH(IBI_DEPTH)) u_ibi_q (
    .clk_i, .rst_ni, .push_i(ibi_push_i), .wdata_i(ibi_data_i), .pop_i(rd_ibi),
    .rdata_o(ibi_head), .level_o(ibi_lvl), .full_o(ibi_full_o), .empty_o(ibi_empty)
  );

  assign cmd_avail_o = ~cmd_empty;
  assign cmd_free    = CLW'(CR_DEPTH) - cmd_lvl;

  qthr_cmp #(.LW(CLW)) u_cmp_cmd  (.count_i(cmd_free), .thr_i(thr.cmd),      .hit_o(cmd_ready_o));
  qthr_cmp #(.LW(CLW)) u_cmp_resp (.count_i(resp_lvl), .thr_i(thr.resp),     .hit_o(resp_ready_o));
  qthr_cmp #(.LW(ILW)) u_cmp_ibi  (.count_i(ibi_lvl),  .thr_i(thr.ibi_stat), .hit_o(ibi_thld_o));

  assign lvl_word  = {3'b000, 9'(ibi_lvl), 1'b0, 9'(resp_lvl), 1'b0, 9'(cmd_free)};
  assign size_word = {16'h0000, 8'(IBI_DEPTH), 8'(CR_DEPTH)};

  always_comb begin
    case (bus_addr_i)
      IDX_RESP: rd_mux = resp_empty ? 32'h0 : resp_head;
      IDX_IBI:  rd_mux = ibi_empty  ? 32'h0 : ibi_head;
      IDX_THR:  rd_mux = 32'(thr);
      IDX_LVL:  rd_mux = lvl_word;
      IDX_SIZE: rd_mux = size_word;
      default:  rd_mux = 32'h0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd_i) rdata_d = rd_mux;
    ovf_d  = wr_cmd & cmd_full;
    rudf_d = rd_resp & resp_empty;
    iudf_d = rd_ibi & ibi_empty;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      ovf_q   <= 1'b0;
      rudf_q  <= 1'b0;
      iudf_q  <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      ovf_q   <= ovf_d;
      rudf_q  <= rudf_d;
      iudf_q  <= iudf_d;
    end
  end

  assign bus_rdata_o    = rdata_q;
  assign err_cmd_ovf_o  = ovf_q;
  assign err_resp_udf_o = rudf_q;
  assign err_ibi_udf_o  = iudf_q;
endmodule

// File: rtl/qthr_chk.sv
module qthr_chk
  import qthr_pkg::*;
#(
  parameter int CR_DEPTH  = 8,
  parameter int IBI_DEPTH = 16,
  localparam int CLW      = $clog2(CR_DEPTH + 1),
  localparam int ILW      = $clog2(IBI_DEPTH + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [2:0]     bus_addr_i,
  input logic           bus_wr_i,
  input logic           bus_rd_i,
  input logic [31:0]    bus_rdata_o,
  input logic           cmd_pop_i,
  input logic           cmd_full,
  input logic [CLW-1:0] cmd_lvl,
  input logic [CLW-1:0] resp_lvl,
  input logic [ILW-1:0] ibi_lvl,
  input logic           cmd_ready_o,
  input logic           resp_ready_o,
  input logic           ibi_thld_o,
  input logic           err_cmd_ovf_o,
  input logic           err_resp_udf_o,
  input logic           err_ibi_udf_o
);
  AST_CMD_OVF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == IDX_CMD && cmd_full) |=> err_cmd_ovf_o); // R10

  AST_CMD_OVF_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == IDX_CMD && cmd_full && !cmd_pop_i) |=> $stable(cmd_lvl)); // R10

  AST_RESP_UDF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == IDX_RESP && resp_lvl == '0) |=> (err_resp_udf_o && bus_rdata_o == 32'h0)); // R11

  AST_IBI_UDF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == IDX_IBI && ibi_lvl == '0) |=> (err_ibi_udf_o && bus_rdata_o == 32'h0)); // R11

  AST_CMD_FULL_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_lvl == CLW'(CR_DEPTH)) |-> !cmd_ready_o); // R3

  AST_RESP_EMPTY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_lvl == '0) |-> !resp_ready_o); // R4

  AST_IBI_EMPTY_NO_THLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ibi_lvl == '0) |-> !ibi_thld_o); // R5
endmodule

bind qthr_top qthr_chk #(.CR_DEPTH(CR_DEPTH), .IBI_DEPTH(IBI_DEPTH)) u_qthr_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
  .bus_rd_i(bus_rd_i), .bus_rdata_o(bus_rdata_o), .cmd_pop_i(cmd_pop_i),
  .cmd_full(cmd_full), .cmd_lvl(cmd_lvl), .resp_lvl(resp_lvl), .ibi_lvl(ibi_lvl),
  .cmd_ready_o(cmd_ready_o), .resp_ready_o(resp_ready_o), .ibi_thld_o(ibi_thld_o),
  .err_cmd_ovf_o(err_cmd_ovf_o), .err_resp_udf_o(err_resp_udf_o), .err_ibi_udf_o(err_ibi_udf_o)
);

// File: tb/tb_qthr_top.sv
`timescale 1ns/1ps
module tb_qthr_top;
  localparam int DEP  = 8;
  localparam int IDEP = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [2:0]  bus_addr_i;
  logic        bus_wr_i, bus_rd_i;
  logic [31:0] bus_wdata_i, bus_rdata_o;
  logic        cmd_pop_i, cmd_avail_o;
  logic [31:0] cmd_data_o;
  logic        resp_push_i, resp_full_o, ibi_push_i, ibi_full_o;
  logic [31:0] resp_data_i, ibi_data_i;
  logic        cmd_ready_o, resp_ready_o, ibi_thld_o;
  logic        err_cmd_ovf_o, err_resp_udf_o, err_ibi_udf_o;

  always #2.5 clk_i = ~clk_i;

  qthr_top #(.CR_DEPTH(DEP), .IBI_DEPTH(IDEP)) dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int          m_cmd = 0;
  logic [31:0] m_thr = 32'h0101_0101;
  logic [31:0] exp_cmd[$];
  logic [31:0] exp_resp[$];
  logic [31:0] exp_ibi[$];
  logic [31:0] rd_exp[$];
  string       rd_tag[$];
  logic        rd_seen;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected read data and compares it when it appears
  always @(posedge clk_i) rd_seen <= rst_ni & bus_rd_i;
  always @(negedge clk_i) begin
    if (rd_seen) begin
      if (rd_exp.size() == 0) chk("R9 unexpected read", 32'h1, 32'h0);
      else chk(rd_tag.pop_front(), bus_rdata_o, rd_exp.pop_front());
    end
  end

  function automatic int eff(logic [7:0] t);
    return (t == 8'd0) ? 1 : int'(t);
  endfunction

  task automatic bus_wr(logic [2:0] a, logic [31:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] a, logic [31:0] e, string tag);
    rd_exp.push_back(e); rd_tag.push_back(tag);
    bus_addr_i = a; bus_rd_i = 1'b1;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
  endtask

  task automatic set_thr(logic [31:0] v);
    bus_wr(3'd3, v);
    m_thr = v;
  endtask

  task automatic check_status(string tag);
    chk({tag, " R3 cmd_ready"},  32'(cmd_ready_o),  32'((DEP - m_cmd) >= eff(m_thr[7:0])));
    chk({tag, " R4 resp_ready"}, 32'(resp_ready_o), 32'(exp_resp.size() >= eff(m_thr[15:8])));
    chk({tag, " R5 ibi_thld"},   32'(ibi_thld_o),   32'(exp_ibi.size() >= eff(m_thr[31:24])));
  endtask

  task automatic read_levels(string tag);
    logic [31:0] e;
    e = {3'b0, 9'(exp_ibi.size()), 1'b0, 9'(exp_resp.size()), 1'b0, 9'(DEP - m_cmd)};
    bus_rd(3'd4, e, {tag, " R6 level register"});
  endtask

  task automatic host_cmd(logic [31:0] d);
    logic ovf;
    ovf = (m_cmd == DEP);
    if (!ovf) begin exp_cmd.push_back(d); m_cmd++; end
    bus_wr(3'd0, d);
    chk("R10 overflow pulse", 32'(err_cmd_ovf_o), 32'(ovf));
  endtask

  task automatic eng_pop();
    chk("R8 cmd_avail before pop", 32'(cmd_avail_o), 32'h1);
    chk("R8 command order", cmd_data_o, exp_cmd.pop_front());
    cmd_pop_i = 1'b1;
    @(negedge clk_i);
    cmd_pop_i = 1'b0;
    m_cmd--;
  endtask

  task automatic eng_resp(logic [31:0] d);
    exp_resp.push_back(d);
    resp_data_i = d; resp_push_i = 1'b1;
    @(negedge clk_i);
    resp_push_i = 1'b0;
  endtask

  task automatic eng_ibi(logic [31:0] d);
    exp_ibi.push_back(d);
    ibi_data_i = d; ibi_push_i = 1'b1;
    @(negedge clk_i);
    ibi_push_i = 1'b0;
  endtask

  task automatic host_rd_resp();
    logic udf;
    udf = (exp_resp.size() == 0);
    bus_rd(3'd1, udf ? 32'h0 : exp_resp.pop_front(), udf ? "R11 empty response read data" : "R9 response order");
    chk("R11 response underflow pulse", 32'(err_resp_udf_o), 32'(udf));
  endtask

  task automatic host_rd_ibi();
    logic udf;
    udf = (exp_ibi.size() == 0);
    bus_rd(3'd2, udf ? 32'h0 : exp_ibi.pop_front(), udf ? "R11 empty IBI read data" : "R9 IBI order");
    chk("R11 IBI underflow pulse", 32'(err_ibi_udf_o), 32'(udf));
  endtask

  initial begin
    #(200_000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    bus_addr_i = '0; bus_wr_i = 0; bus_rd_i = 0; bus_wdata_i = '0;
    cmd_pop_i = 0; resp_push_i = 0; ibi_push_i = 0; resp_data_i = '0; ibi_data_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 cmd_ready after reset", 32'(cmd_ready_o), 32'h1);
    chk("R1 resp_ready after reset", 32'(resp_ready_o), 32'h0);
    chk("R1 ibi_thld after reset", 32'(ibi_thld_o), 32'h0);
    chk("R1 cmd_avail after reset", 32'(cmd_avail_o), 32'h0);
    bus_rd(3'd3, 32'h0101_0101, "R1 threshold reset value");
    read_levels("R1");
    bus_rd(3'd5, 32'(IDEP << 8) | 32'(DEP), "R7 size register");

    // R2 threshold readback
    set_thr(32'h0322_0205);
    bus_rd(3'd3, 32'h0322_0205, "R2 threshold readback");
    check_status("R2");

    // R3 fill the command queue, ready tracks free slots against 5
    for (int i = 0; i < DEP; i++) begin
      host_cmd(32'hC000_0000 + 32'(i));
      check_status("R3 fill");
    end
    host_cmd(32'hDEAD_BEEF);
    @(negedge clk_i);
    chk("R10 overflow pulse lasts one cycle", 32'(err_cmd_ovf_o), 32'h0);
    read_levels("R10");

    // R8 drain in order, overflow word absent
    for (int i = 0; i < DEP; i++) eng_pop();
    chk("R8 cmd_avail when empty", 32'(cmd_avail_o), 32'h0);

    // R3 zero threshold counts as one; threshold above depth
    set_thr(32'h0322_0200);
    check_status("R3 zero threshold");
    host_cmd(32'h1234_5678);
    check_status("R3 zero threshold one used");
    eng_pop();
    set_thr(32'h0322_0209);
    check_status("R3 threshold above depth");

    // R4 response threshold 2
    eng_resp(32'hA000_0001);
    check_status("R4 one response");
    eng_resp(32'hA000_0002);
    check_status("R4 two responses");
    host_rd_resp();
    check_status("R4 after read");
    host_rd_resp();
    host_rd_resp();
    read_levels("R11 after response underflow");

    // R4 zero threshold
    set_thr(32'h0322_0009);
    eng_resp(32'hA000_0003);
    check_status("R4 zero threshold");
    host_rd_resp();

    // R12 fill the response queue, R9 order
    for (int i = 0; i < DEP; i++) eng_resp(32'hB000_0000 + 32'(i));
    chk("R12 resp_full", 32'(resp_full_o), 32'h1);
    read_levels("R12");
    for (int i = 0; i < DEP; i++) host_rd_resp();
    chk("R12 resp_full after drain", 32'(resp_full_o), 32'h0);

    // R5 IBI status threshold 3
    for (int i = 0; i < 3; i++) begin
      eng_ibi(32'hE000_0000 + 32'(i));
      check_status("R5 IBI fill");
    end
    read_levels("R5");
    for (int i = 0; i < 4; i++) host_rd_ibi();
    check_status("R5 IBI drained");

    // R5 zero threshold; R12 IBI full
    set_thr(32'h0022_0009);
    eng_ibi(32'hE100_0000);
    check_status("R5 zero threshold");
    for (int i = 1; i < IDEP; i++) eng_ibi(32'hE100_0000 + 32'(i));
    chk("R12 ibi_full", 32'(ibi_full_o), 32'h1);
    for (int i = 0; i < IDEP; i++) host_rd_ibi();
    chk("R12 ibi_full after drain", 32'(ibi_full_o), 32'h0);
    @(negedge clk_i);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule